// File: doc/BRIEF.md
# Integer ALU with Packed Status Flags

This block performs one integer operation per cycle on two operands: addition, subtraction, a flags-only compare, and bitwise AND, OR or XOR. When the input strobe is high on a clock edge, it registers the arithmetic or logic result. It also registers a 32-bit status word that holds six condition flags at fixed, sparse bit positions. The other positions in that word always read as zero.

A compare computes the first operand minus the second and updates the status word. It does not update the result register and does not raise the write-enable. The write-enable output tells a downstream register file when the registered result is meant to be stored. The datapath width is a parameter, with a minimum of 8 bits. The status word is 32 bits at any datapath width.

Top module: `alu_status_flags`

## Requirements
- R1: Opcode 3'd0 (add) registers `a_i + b_i` modulo 2^WIDTH, and sets the carry flag at status bit 0 when the unsigned sum does not fit in WIDTH bits.
- R2: Opcodes 3'd1 (subtract) and 3'd2 (compare) compute `a_i - b_i` modulo 2^WIDTH. Bit 0 is set when `a_i < b_i` as unsigned values (a borrow). Subtract registers the difference.
- R3: Status bit 11 is set for add or subtract/compare when the two's-complement result lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R4: Status bit 4 is set on a carry out of bit 3 for add, or a borrow into bit 3 for subtract/compare.
- R5: Status bit 2 is set when bits [7:0] of the computed value hold an even number of ones.
- R6: Status bit 6 is set when the computed value is zero, and status bit 7 equals its most significant bit.
- R7: Compare updates the status word, leaves `result_o` unchanged and drives `wr_en_o` low in the following cycle.
- R8: Opcodes 3'd3, 3'd4 and 3'd5 register `a_i & b_i`, `a_i | b_i` and `a_i ^ b_i`, and clear status bits 0, 4 and 11.
- R9: Every status bit other than 0, 2, 4, 6, 7 and 11 reads as zero.
- R10: Outputs update only on a clock edge with `valid_i` high. With `valid_i` low, or with opcode 3'd6 or 3'd7, `result_o` and `flags_o` hold their values and `wr_en_o` is low in the following cycle. `wr_en_o` is high after a valid add, subtract or logic operation.
- R11: While `rst_n` is low, `result_o`, `flags_o` and `wr_en_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation select |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| result_o | output | WIDTH | Registered result |
| flags_o | output | 32 | Registered status word |
| wr_en_o | output | 1 | Result-store enable for the last operation |

## Verification
Addition is swept over every operand pair at an 8-bit width. This separates unsigned carry from signed overflow, and carry from bit 3 from carry out of the top bit. Subtraction covers every first operand against every even second operand, and this shows whether borrow and auxiliary borrow are inverted correctly. Compare and the logic operations are run on strided grids that reach zero results, negative results and both parity outcomes. Runs with the strobe low and with unused opcodes, placed between these grids, show that both the result and the status word are held.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int FLAG_W = 32;

    localparam int FLG_CF = 0;
    localparam int FLG_PF = 2;
    localparam int FLG_AF = 4;
    localparam int FLG_ZF = 6;
    localparam int FLG_SF = 7;
    localparam int FLG_OF = 11;

    localparam logic [FLAG_W-1:0] FLAG_MASK =
        (32'd1 << FLG_CF) | (32'd1 << FLG_PF) | (32'd1 << FLG_AF) |
        (32'd1 << FLG_ZF) | (32'd1 << FLG_SF) | (32'd1 << FLG_OF);

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_CMP = 3'd2,
        OP_AND = 3'd3,
        OP_OR  = 3'd4,
        OP_XOR = 3'd5
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic aux;
        logic ovf;
    } arith_flags_t;

endpackage

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output arith_flags_t     flg_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;
    logic [4:0]       nib;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        full  = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
        nib   = {1'b0, a_i[3:0]} + {1'b0, b_eff[3:0]} + {4'd0, sub_i};
        sum_o = full[WIDTH-1:0];
        // Subtraction by inverted-add: no carry out means a borrow occurred
        flg_o.carry = full[WIDTH] ^ sub_i;
        flg_o.aux   = nib[4] ^ sub_i;
        flg_o.ovf   = (a_i[MSB] == b_eff[MSB]) && (full[MSB] != a_i[MSB]);
    end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  alu_op_e          op_i,
    output logic [WIDTH-1:0] y_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:  y_o = a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            default: y_o = a_i ^ b_i;
        endcase
    end
endmodule

// File: rtl/alu_flag_pack.sv
module alu_flag_pack
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]  value_i,
    input  arith_flags_t      arith_i,
    output logic [FLAG_W-1:0] word_o
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        word_o         = '0;
        word_o[FLG_CF] = arith_i.carry;
        word_o[FLG_PF] = ~^value_i[7:0];
        word_o[FLG_AF] = arith_i.aux;
        word_o[FLG_ZF] = (value_i == '0);
        word_o[FLG_SF] = value_i[MSB];
        word_o[FLG_OF] = arith_i.ovf;
    end
endmodule

// File: rtl/alu_status_flags.sv
module alu_status_flags
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [2:0]        op_i,
    input  logic [WIDTH-1:0]  a_i,
    input  logic [WIDTH-1:0]  b_i,
    output logic [WIDTH-1:0]  result_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              wr_en_o
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0]  result;
        logic [FLAG_W-1:0] flags;
        logic              wr;
    } state_t;

    state_t st_d, st_q;

    alu_op_e          op;
    logic             is_arith;
    logic             is_logic;
    logic [WIDTH-1:0] arith_val;
    logic [WIDTH-1:0] logic_val;
    logic [WIDTH-1:0] sel_val;
    arith_flags_t     arith_flg;
    arith_flags_t     sel_flg;
    logic [FLAG_W-1:0] word;

    assign op       = alu_op_e'(op_i);
    assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
    assign is_logic = (op == OP_AND) || (op == OP_OR)  || (op == OP_XOR);

    alu_arith_unit #(.WIDTH(WIDTH)) u_arith (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (op != OP_ADD),
        .sum_o (arith_val),
        .flg_o (arith_flg)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a_i  (a_i),
        .b_i  (b_i),
        .op_i (op),
        .y_o  (logic_val)
    );

    always_comb begin
        sel_val = is_arith ? arith_val : logic_val;
        sel_flg = is_arith ? arith_flg : '0;
    end

    alu_flag_pack #(.WIDTH(WIDTH)) u_pack (
        .value_i (sel_val),
        .arith_i (sel_flg),
        .word_o  (word)
    );

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        if (valid_i && (is_arith || is_logic)) begin
            st_d.flags = word;
            if (op != OP_CMP) begin
                st_d.result = sel_val;
                st_d.wr     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.result;
    assign flags_o  = st_q.flags;
    assign wr_en_o  = st_q.wr;

    assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd2) |=> ($stable(result_o) && !wr_en_o));

    assert_logic_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == 3'd3 || op_i == 3'd4 || op_i == 3'd5))
        |=> (!flags_o[FLG_CF] && !flags_o[FLG_AF] && !flags_o[FLG_OF]));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & ~FLAG_MASK) == '0);

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(result_o) && $stable(flags_o) && !wr_en_o));

    assert_zero_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (flags_o[FLG_ZF] == (result_o == '0) &&
                     flags_o[FLG_SF] == result_o[MSB]));

    assert_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (flags_o[FLG_PF] == ($countones(result_o[7:0]) % 2 == 0)));

    assert_add_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd0) |=>
        (flags_o[FLG_CF] == (result_o < $past(a_i))));

endmodule

// File: tb/alu_status_flags_bench.sv
module alu_status_flags_bench;
    localparam int W = 8;
    localparam int M = 1 << W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [2:0]    op_i = 3'd0;
    logic [W-1:0]  a_i = '0;
    logic [W-1:0]  b_i = '0;
    logic [W-1:0]  result_o;
    logic [31:0]   flags_o;
    logic          wr_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int exp_res = 0;
    int exp_flags = 0;
    int exp_wr = 0;
    int cur_op = 0;

    always #10 clk = ~clk;

    alu_status_flags #(.WIDTH(W)) u_alu_status_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid_i),
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .result_o (result_o),
        .flags_o  (flags_o),
        .wr_en_o  (wr_en_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%0d b=%0d actual=%0h expected=%0h",
                     tag, cur_op, a_i, b_i, act, exp);
        end
    endtask

    task automatic check_outputs(input string res_tag, input string wr_tag);
        int f;
        f = int'(flags_o);
        chk(res_tag, int'(result_o), exp_res);
        chk(wr_tag, int'(wr_en_o), exp_wr);
        if (cur_op >= 3 && cur_op <= 5) begin
            chk("R8 carry", f & 1, exp_flags & 1);
            chk("R8 ovf", (f >> 11) & 1, (exp_flags >> 11) & 1);
        end else begin
            chk("R1 R2 carry", f & 1, exp_flags & 1);
            chk("R3 ovf", (f >> 11) & 1, (exp_flags >> 11) & 1);
        end
        chk("R4 aux", (f >> 4) & 1, (exp_flags >> 4) & 1);
        chk("R5 parity", (f >> 2) & 1, (exp_flags >> 2) & 1);
        chk("R6 zero/sign", (f >> 6) & 3, (exp_flags >> 6) & 3);
        chk("R9 reserved", f & ~32'h08D5, 0);
    endtask

    // Drive one cycle, then check at the next falling edge
    task automatic apply(input bit v, input int op, input int a, input int b);
        int sa, sb, s, sr, r, cf, af, of, pf, ones;
        cur_op = op;
        valid_i = v;
        op_i = 3'(op);
        a_i = W'(a);
        b_i = W'(b);
        sa = (a >= M/2) ? a - M : a;
        sb = (b >= M/2) ? b - M : b;
        r = 0; cf = 0; af = 0; of = 0; sr = 0;
        case (op)
            0: begin
                s = a + b; r = s % M; cf = (s >= M) ? 1 : 0;
                af = ((a % 16) + (b % 16) >= 16) ? 1 : 0;
                sr = sa + sb;
            end
            1, 2: begin
                s = a - b; r = (s + M) % M; cf = (a < b) ? 1 : 0;
                af = ((a % 16) < (b % 16)) ? 1 : 0;
                sr = sa - sb;
            end
            3: r = a & b;
            4: r = a | b;
            5: r = a ^ b;
            default: r = 0;
        endcase
        if (op <= 2) of = (sr > M/2 - 1 || sr < -(M/2)) ? 1 : 0;
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        pf = (ones % 2 == 0) ? 1 : 0;
        exp_wr = 0;
        if (v && op <= 5) begin
            exp_flags = cf | (pf << 2) | (af << 4) | ((r == 0 ? 1 : 0) << 6) |
                        ((r >= M/2 ? 1 : 0) << 7) | (of << 11);
            if (op != 2) begin
                exp_res = r;
                exp_wr = 1;
            end
        end
        @(negedge clk);
        if (!v || op > 5)      check_outputs("R10 hold", "R10 wr_en");
        else if (op == 0)      check_outputs("R1 sum", "R10 wr_en");
        else if (op == 1)      check_outputs("R2 diff", "R10 wr_en");
        else if (op == 2)      check_outputs("R7 result held", "R7 wr_en");
        else                   check_outputs("R8 logic", "R10 wr_en");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 result", int'(result_o), 0);
        chk("R11 flags", int'(flags_o), 0);
        chk("R11 wr_en", int'(wr_en_o), 0);
        rst_n = 1'b1;

        for (int a = 0; a < M; a++)
            for (int b = 0; b < M; b++)
                apply(1'b1, 0, a, b);

        apply(1'b0, 1, 200, 9);
        apply(1'b1, 6, 0, 0);
        apply(1'b1, 7, 5, 5);

        for (int a = 0; a < M; a++)
            for (int b = 0; b < M; b += 2)
                apply(1'b1, 1, a, b);

        for (int a = 0; a < M; a += 5)
            for (int b = 0; b < M; b += 5) begin
                apply(1'b1, 2, a, b);
                if (a == b) apply(1'b0, 0, a, 1);
            end

        for (int op = 3; op <= 5; op++) begin
            for (int a = 0; a < M; a += 3)
                for (int b = 0; b < M; b += 7)
                    apply(1'b1, op, a, b);
            apply(1'b1, 2, 16, 32);
            apply(1'b1, 6, 255, 255);
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule